// File: doc/BRIEF.md
# Stable Descending Score Sorter

This block orders score/index pairs in fixed groups of 32. A single command carries a repeat count N. After the command is accepted, the block takes N consecutive groups from a valid/ready input stream. Each beat of that stream carries one 32-bit score and the 32-bit index that goes with it, and the two are paired by their position in the stream. For each group the block returns 32 packed 64-bit records on a valid/ready output stream, ordered from the highest score down to the lowest.

Scores are compared as IEEE-754 single-precision values. Ties keep the order in which they arrived. The two zeros count as equal. NaN inputs are outside the supported range.

Insertion takes place while the group arrives. Each accepted pair drops straight into its final slot, so draining can begin on the cycle after the 32nd pair. Loading and draining alternate, and two groups never overlap. A one-cycle done pulse marks the end of the command.

Top module: `stable_desc_sorter`

## Requirements
- R1: Each group of 32 accepted pairs yields exactly 32 output records. No further record appears until the next group has been fully loaded.
- R2: Within a group, records leave in non-increasing score order. The order is that of the floating-point values: any positive value ranks above any negative value, a larger magnitude ranks higher among positives, and a smaller magnitude ranks higher among negatives.
- R3: Records whose scores compare equal leave in their arrival order. Positive zero (0x00000000) and negative zero (0x80000000) compare equal.
- R4: A record carries the index in bits [63:32] and the score in bits [31:0]. Both are exactly the bits received, including the sign of a zero.
- R5: A command with repeat count N > 0 processes N groups. `done` goes high for one cycle, in the cycle after the handshake of the last record of the last group, and never earlier.
- R6: A command with repeat count 0 produces no records and no input requests. `done` goes high in the cycle after the command handshake.
- R7: `in_ready` is high only while a group is loading, and `out_valid` is high only while a group is draining. The two are never high together, and the drain begins right after the 32nd input handshake.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_record` holds its value.
- R9: `cmd_ready` is high only when no command is running. A command presented during a run is not taken and does not change the number of records produced.
- R10: During and right after reset, `cmd_ready` is 1 and `in_ready`, `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | A command can be taken (block idle) |
| cmd_repeat | input | REPEAT_W (16) | Number of 32-pair groups in the command |
| in_valid | input | 1 | A score/index pair is offered |
| in_ready | output | 1 | A pair can be taken (group loading) |
| in_score | input | SCORE_W (32) | Score bits of the pair |
| in_index | input | INDEX_W (32) | Index bits of the pair |
| out_valid | output | 1 | A sorted record is offered |
| out_ready | input | 1 | Downstream takes the record |
| out_record | output | INDEX_W+SCORE_W (64) | Index in the upper half, score in the lower half |
| done | output | 1 | One-cycle pulse at the end of a command |

## Verification
The assertions check on every cycle the properties that can be stated for each cycle on its own:
- the non-increasing score order between consecutive records of a group;
- the load/drain exclusion and the switch to draining after the 32nd pair;
- the end of a group's output after its 32nd record;
- the hold of a record under backpressure;
- the done pulse that follows a zero-count command.

Three behaviours need a model of the whole group, and only the bench scenarios can show them. These are the stability of ties (including mixed-sign zeros), the exact index and score bits in each position, and the number of records and done pulses across multi-group commands. The bench also covers a command offered in the middle of a load.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_DRAIN = 2'd2
   } sort_state_e;

   // Monotonic unsigned ordering key for a single-precision value.
   // Negative zero is folded onto positive zero before mapping.
   function automatic logic [31:0] f32_order_key(input logic [31:0] raw);
      logic [31:0] norm;
      norm = (raw == 32'h8000_0000) ? 32'h0000_0000 : raw;
      return norm[31] ? ~norm : (norm | 32'h8000_0000);
   endfunction

endpackage

// File: rtl/sorter_key_map.sv
module sorter_key_map #(
   parameter int SCORE_W    = 32,
   parameter bit FLOAT_KEYS = 1'b1
) (
   input  logic [SCORE_W-1:0] score,
   output logic [SCORE_W-1:0] key
);

   generate
      if (FLOAT_KEYS) begin : g_float
         assign key = sorter_pkg::f32_order_key(score);
      end else begin : g_unsigned
         assign key = score;
      end
   endgenerate

endmodule

// File: rtl/sorter_insert_array.sv
module sorter_insert_array #(
   parameter int GROUP_SIZE = 32,
   parameter int SCORE_W    = 32,
   parameter int INDEX_W    = 32,
   parameter bit FLOAT_KEYS = 1'b1,
   parameter int POS_W      = $clog2(GROUP_SIZE + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ins_en,
   input  logic [SCORE_W-1:0] ins_score,
   input  logic [INDEX_W-1:0] ins_index,
   input  logic [POS_W-1:0]   fill_cnt,
   input  logic               pop_en,
   output logic [SCORE_W-1:0] head_score,
   output logic [INDEX_W-1:0] head_index
);

   logic [SCORE_W-1:0]    slot_score [GROUP_SIZE];
   logic [INDEX_W-1:0]    slot_index [GROUP_SIZE];
   logic [SCORE_W-1:0]    slot_key   [GROUP_SIZE];
   logic [GROUP_SIZE-1:0] keep_slot;
   logic [SCORE_W-1:0]    ins_key;

   sorter_key_map #(
      .SCORE_W    (SCORE_W),
      .FLOAT_KEYS (FLOAT_KEYS)
   ) u_ins_key (
      .score (ins_score),
      .key   (ins_key)
   );

   generate
      for (genvar i = 0; i < GROUP_SIZE; i++) begin : g_slot
         logic [SCORE_W-1:0] score_q;
         logic [INDEX_W-1:0] index_q;
         logic [SCORE_W-1:0] dn_score;
         logic [INDEX_W-1:0] dn_index;
         logic [SCORE_W-1:0] up_score;
         logic [INDEX_W-1:0] up_index;

         sorter_key_map #(
            .SCORE_W    (SCORE_W),
            .FLOAT_KEYS (FLOAT_KEYS)
         ) u_key (
            .score (score_q),
            .key   (slot_key[i])
         );

         assign slot_score[i] = score_q;
         assign slot_index[i] = index_q;

         // An occupied slot whose key is at least the newcomer's stays put;
         // equal keys stay ahead, which keeps arrival order among ties.
         assign keep_slot[i] = (POS_W'(i) < fill_cnt) && (slot_key[i] >= ins_key);

         if (i == 0) begin : g_first
            assign dn_score = ins_score;
            assign dn_index = ins_index;
         end else begin : g_rest
            assign dn_score = keep_slot[i-1] ? ins_score : slot_score[i-1];
            assign dn_index = keep_slot[i-1] ? ins_index : slot_index[i-1];
         end

         if (i == GROUP_SIZE - 1) begin : g_tail
            assign up_score = score_q;
            assign up_index = index_q;
         end else begin : g_body
            assign up_score = slot_score[i+1];
            assign up_index = slot_index[i+1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               score_q <= '0;
               index_q <= '0;
            end else if (ins_en && !keep_slot[i]) begin
               score_q <= dn_score;
               index_q <= dn_index;
            end else if (pop_en) begin
               score_q <= up_score;
               index_q <= up_index;
            end
         end
      end
   endgenerate

   assign head_score = slot_score[0];
   assign head_index = slot_index[0];

endmodule

// File: rtl/sorter_ctrl.sv
module sorter_ctrl #(
   parameter int GROUP_SIZE = 32,
   parameter int REPEAT_W   = 16,
   parameter int POS_W      = $clog2(GROUP_SIZE + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [REPEAT_W-1:0] cmd_repeat,
   input  logic                in_valid,
   input  logic                out_ready,
   output logic                cmd_ready,
   output logic                in_ready,
   output logic                out_valid,
   output logic                ins_en,
   output logic                pop_en,
   output logic [POS_W-1:0]    fill_cnt,
   output logic                done
);

   import sorter_pkg::*;

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(GROUP_SIZE - 1);
   localparam logic [POS_W-1:0] ONE_POS  = POS_W'(1);

   sort_state_e         state_q;
   logic [REPEAT_W-1:0] groups_left_q;
   logic [POS_W-1:0]    occ_q;
   logic                done_q;

   always_comb begin
      cmd_ready = (state_q == ST_IDLE);
      in_ready  = (state_q == ST_LOAD);
      out_valid = (state_q == ST_DRAIN);
      ins_en    = in_ready && in_valid;
      pop_en    = out_valid && out_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         groups_left_q <= '0;
         occ_q         <= '0;
         done_q        <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  if (cmd_repeat == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     groups_left_q <= cmd_repeat;
                     occ_q         <= '0;
                     state_q       <= ST_LOAD;
                  end
               end
            end
            ST_LOAD: begin
               if (ins_en) begin
                  occ_q <= occ_q + ONE_POS;
                  if (occ_q == LAST_POS) begin
                     state_q <= ST_DRAIN;
                  end
               end
            end
            ST_DRAIN: begin
               if (pop_en) begin
                  occ_q <= occ_q - ONE_POS;
                  if (occ_q == ONE_POS) begin
                     if (groups_left_q == REPEAT_W'(1)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        groups_left_q <= groups_left_q - REPEAT_W'(1);
                        state_q       <= ST_LOAD;
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign fill_cnt = occ_q;
   assign done     = done_q;

endmodule

// File: rtl/stable_desc_sorter.sv
module stable_desc_sorter #(
   parameter int GROUP_SIZE = 32,
   parameter int SCORE_W    = 32,
   parameter int INDEX_W    = 32,
   parameter int REPEAT_W   = 16,
   parameter bit FLOAT_KEYS = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   output logic                       cmd_ready,
   input  logic [REPEAT_W-1:0]        cmd_repeat,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [SCORE_W-1:0]         in_score,
   input  logic [INDEX_W-1:0]         in_index,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [INDEX_W+SCORE_W-1:0] out_record,
   output logic                       done
);

   localparam int POS_W = $clog2(GROUP_SIZE + 1);

   generate
      if (GROUP_SIZE < 2) begin : g_bad_group
         $error("stable_desc_sorter: GROUP_SIZE must be at least 2");
      end
      if (FLOAT_KEYS && (SCORE_W != 32)) begin : g_bad_float
         $error("stable_desc_sorter: floating-point keys need SCORE_W of 32");
      end
      if (REPEAT_W < 1) begin : g_bad_repeat
         $error("stable_desc_sorter: REPEAT_W must be positive");
      end
   endgenerate

   logic               ins_en;
   logic               pop_en;
   logic [POS_W-1:0]   fill_cnt;
   logic [SCORE_W-1:0] head_score;
   logic [INDEX_W-1:0] head_index;

   sorter_ctrl #(
      .GROUP_SIZE (GROUP_SIZE),
      .REPEAT_W   (REPEAT_W),
      .POS_W      (POS_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_repeat (cmd_repeat),
      .in_valid   (in_valid),
      .out_ready  (out_ready),
      .cmd_ready  (cmd_ready),
      .in_ready   (in_ready),
      .out_valid  (out_valid),
      .ins_en     (ins_en),
      .pop_en     (pop_en),
      .fill_cnt   (fill_cnt),
      .done       (done)
   );

   sorter_insert_array #(
      .GROUP_SIZE (GROUP_SIZE),
      .SCORE_W    (SCORE_W),
      .INDEX_W    (INDEX_W),
      .FLOAT_KEYS (FLOAT_KEYS),
      .POS_W      (POS_W)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_en     (ins_en),
      .ins_score  (in_score),
      .ins_index  (in_index),
      .fill_cnt   (fill_cnt),
      .pop_en     (pop_en),
      .head_score (head_score),
      .head_index (head_index)
   );

   assign out_record = {head_index, head_score};

endmodule

// File: rtl/stable_desc_sorter_chk.sv
module stable_desc_sorter_chk #(
   parameter int GROUP_SIZE = 32,
   parameter int SCORE_W    = 32,
   parameter int INDEX_W    = 32,
   parameter int REPEAT_W   = 16,
   parameter bit FLOAT_KEYS = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cmd_valid,
   input logic                       cmd_ready,
   input logic [REPEAT_W-1:0]        cmd_repeat,
   input logic                       in_valid,
   input logic                       in_ready,
   input logic                       out_valid,
   input logic                       out_ready,
   input logic [INDEX_W+SCORE_W-1:0] out_record,
   input logic                       done
);

   localparam int POS_W = $clog2(GROUP_SIZE + 1);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(GROUP_SIZE - 1);

   logic               out_fire;
   logic               in_fire;
   logic [SCORE_W-1:0] out_key;
   logic [SCORE_W-1:0] prev_key_q;
   logic [POS_W-1:0]   out_pos_q;
   logic [POS_W-1:0]   in_pos_q;

   assign out_fire = out_valid && out_ready;
   assign in_fire  = in_valid && in_ready;

   sorter_key_map #(
      .SCORE_W    (SCORE_W),
      .FLOAT_KEYS (FLOAT_KEYS)
   ) u_chk_key (
      .score (out_record[SCORE_W-1:0]),
      .key   (out_key)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_key_q <= '0;
         out_pos_q  <= '0;
         in_pos_q   <= '0;
      end else begin
         if (out_fire) begin
            prev_key_q <= out_key;
            out_pos_q  <= (out_pos_q == LAST_POS) ? '0 : out_pos_q + POS_W'(1);
         end
         if (in_fire) begin
            in_pos_q <= (in_pos_q == LAST_POS) ? '0 : in_pos_q + POS_W'(1);
         end
      end
   end

   p_desc_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && (out_pos_q != '0)) |-> (out_key <= prev_key_q));

   p_group_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && (out_pos_q == LAST_POS)) |=> !out_valid);

   p_load_to_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && (in_pos_q == LAST_POS)) |=> (!in_ready && out_valid));

   p_one_role_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_ready, in_ready, out_valid}));

   p_hold_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_record)));

   p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cmd_ready && !out_valid && !in_ready));

   p_zero_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && (cmd_repeat == '0)) |=> (done && cmd_ready));

endmodule

bind stable_desc_sorter stable_desc_sorter_chk #(
   .GROUP_SIZE (GROUP_SIZE),
   .SCORE_W    (SCORE_W),
   .INDEX_W    (INDEX_W),
   .REPEAT_W   (REPEAT_W),
   .FLOAT_KEYS (FLOAT_KEYS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_repeat (cmd_repeat),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_record (out_record),
   .done       (done)
);

// File: tb/stable_desc_sorter_bench.sv
`timescale 1ns/1ps
module stable_desc_sorter_bench;

   localparam int G  = 32;
   localparam int RW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_valid;
   logic          cmd_ready;
   logic [RW-1:0] cmd_repeat;
   logic          in_valid;
   logic          in_ready;
   logic [31:0]   in_score;
   logic [31:0]   in_index;
   logic          out_valid;
   logic          out_ready;
   logic [63:0]   out_record;
   logic          done;

   stable_desc_sorter u_stable_desc_sorter (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_repeat (cmd_repeat),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_score   (in_score),
      .in_index   (in_index),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_record (out_record),
      .done       (done)
   );

   always #10 clk = ~clk;   // 50 MHz

   int          n_checks = 0;
   int          n_fails  = 0;
   bit          finished = 0;
   bit          bp_mode  = 0;
   bit          inject_cmd = 0;
   logic [63:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // a ranks strictly above b as single-precision values (no NaN)
   function automatic bit ranks_above(input logic [31:0] a, input logic [31:0] b);
      if (a[30:0] == 0 && b[30:0] == 0) return 1'b0;
      if (a[31] != b[31]) return !a[31];
      if (!a[31]) return a[30:0] > b[30:0];
      return a[30:0] < b[30:0];
   endfunction

   function automatic logic [31:0] gen_score(input int pat, input int pos);
      logic [31:0] r;
      logic [7:0]  e;
      r = $urandom;
      e = 8'($urandom % 255);
      case (pat)
         1: return pos[0] ? 32'h8000_0000 : 32'h0000_0000;
         2: return 32'h3F80_0000 + (32'(pos) << 20);
         3: begin
            case ($urandom % 5)
               0: return 32'hBF80_0000;
               1: return 32'h3F80_0000;
               2: return 32'h0000_0000;
               3: return 32'h8000_0000;
               default: return 32'h4000_0000;
            endcase
         end
         4: return {1'b1, e, r[22:0]};
         5: return 32'h4200_0000 - (32'(pos / 4) << 20);
         default: return {r[31], e, r[22:0]};
      endcase
   endfunction

   task automatic produce_group(input int pat);
      logic [31:0] sc[G];
      logic [31:0] ix[G];
      bit          used[G];
      for (int p = 0; p < G; p++) begin
         sc[p]   = gen_score(pat, p);
         ix[p]   = {27'($urandom), 5'(p)};
         used[p] = 1'b0;
      end
      // stable selection: the earliest of the highest-ranked remaining
      for (int k = 0; k < G; k++) begin
         int best = -1;
         for (int p = 0; p < G; p++) begin
            if (!used[p] && (best < 0 || ranks_above(sc[p], sc[best]))) best = p;
         end
         used[best] = 1'b1;
         exp_q.push_back({ix[best], sc[best]});
      end
      for (int p = 0; p < G; p++) begin
         bit taken = 0;
         while (!taken) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (inject_cmd && p == 10) begin
               cmd_valid  = 1'b1;
               cmd_repeat = RW'(5);
               chk(cmd_ready == 1'b0, "R9 cmd_ready during load", 64'(cmd_ready), 64'd0);
            end
            if (($urandom % 5) == 0) begin
               in_valid = 1'b0;
            end else begin
               in_valid = 1'b1;
               in_score = sc[p];
               in_index = ix[p];
               if (in_ready) begin
                  @(posedge clk);
                  taken = 1;
               end
            end
         end
      end
      @(negedge clk);
      in_valid  = 1'b0;
      cmd_valid = 1'b0;
   endtask

   task automatic drive_groups(input int n, input int pat);
      for (int g = 0; g < n; g++) produce_group((pat < 0) ? int'($urandom % 6) : pat);
   endtask

   task automatic consume(input int total);
      int          got = 0;
      bit          early = 0;
      bit          overlap = 0;
      logic [63:0] exp;
      while (got < total) begin
         @(negedge clk);
         out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
         if (done) early = 1;
         if (out_valid && in_ready) overlap = 1;
         if (out_valid && out_ready) begin
            exp = exp_q.pop_front();
            chk(out_record == exp, "R2/R3/R4 sorted record", out_record, exp);
            got++;
            @(posedge clk);
         end
      end
      @(negedge clk);
      out_ready = 1'b0;
      chk(done == 1'b1, "R5 done after last record", 64'(done), 64'd1);
      chk(!early, "R5 no early done", 64'(early), 64'd0);
      chk(!overlap, "R7 load and drain exclusive", 64'(overlap), 64'd0);
      @(negedge clk);
      chk(done == 1'b0, "R5 done lasts one cycle", 64'(done), 64'd0);
      out_ready = 1'b1;
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0 && cmd_ready == 1'b1, "R1 no extra records",
          {62'd0, out_valid, cmd_ready}, 64'd1);
      out_ready = 1'b0;
   endtask

   task automatic run_cmd(input int n, input int pat);
      @(negedge clk);
      cmd_valid  = 1'b1;
      cmd_repeat = RW'(n);
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (n == 0) begin
         chk(done == 1'b1, "R6 zero repeat done", 64'(done), 64'd1);
         chk(!in_ready && !out_valid, "R6 zero repeat quiet", {62'd0, in_ready, out_valid}, 64'd0);
         @(negedge clk);
         chk(done == 1'b0 && cmd_ready == 1'b1, "R6 back to idle", {62'd0, done, cmd_ready}, 64'd1);
      end else begin
         chk(in_ready == 1'b1, "R7 load after command", 64'(in_ready), 64'd1);
         fork
            drive_groups(n, pat);
            consume(n * G);
         join
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n      = 1'b0;
      cmd_valid  = 1'b0;
      cmd_repeat = '0;
      in_valid   = 1'b0;
      in_score   = '0;
      in_index   = '0;
      out_ready  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(cmd_ready && !in_ready && !out_valid && !done, "R10 reset state",
          {60'd0, cmd_ready, in_ready, out_valid, done}, 64'h8);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready && !in_ready && !out_valid && !done, "R10 after reset",
          {60'd0, cmd_ready, in_ready, out_valid, done}, 64'h8);

      run_cmd(0, 0);          // R6
      run_cmd(1, 1);          // R3 mixed-sign zero ties, R4 sign kept
      run_cmd(1, 2);          // R2 ascending input
      run_cmd(1, 5);          // R3 pre-sorted with ties
      bp_mode = 1;
      run_cmd(2, 3);          // R3 few distinct values, R8 backpressure
      inject_cmd = 1;
      run_cmd(1, 0);          // R9 command during load
      inject_cmd = 0;
      run_cmd(3, 4);          // R5 multi-group, negative values
      bp_mode = 0;
      for (int t = 0; t < 4; t++) run_cmd(1 + int'($urandom % 2), -1);
      run_cmd(0, 0);          // R6 again after activity

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule